// File: doc/BRIEF.md
# Flash Sector Lock Sequencer

This block runs the in-system sequences that lock and unlock the sectors of a parallel flash device. It does not drive the device pins. It issues single bus cycles (a write or a read at a given address) through a request/done handshake to a bus engine placed outside it. It raises a flag that tells external circuitry to put the high programming voltage on the device's reset pin. All waits are counted in clock cycles, derived from the clock frequency parameter in MHz.

Two jobs are supported. The first locks one chosen sector. It pulses, waits, verifies and retries until the sector reads back as locked or the pulse budget runs out. The second unlocks the whole device. It first checks every sector and locks any sector that is not yet locked. It then walks all sectors in ascending order, pulsing and verifying each one until it reads back as unlocked. Both jobs end the same way: the high-voltage flag is dropped, a reset command is written, and a one-cycle done pulse carries the pass flag and the index of the sector that failed.

Top module: `sector_guard_seq`

## Requirements
- R1: Out of reset and whenever `busy` is low, `hv_en`, `bus_req` and `done` are low.
- R2: A `start` seen while idle raises `busy` and `hv_en`. No bus request is issued until at least SETTLE_US×CLK_MHZ cycles after `hv_en` rose.
- R3: A lock pulse is a write of 60h to the sector base address with bit 6 = 0, bit 1 = 1 and bit 0 = 0. It is followed, at least PROT_WAIT_US×CLK_MHZ cycles after the pulse completes, by a write of 40h to the same address and then a read of that address.
- R4: In single-sector mode, a read-back of 01h ends the job with pass = 1. Any other value triggers another pulse. After PROT_LIMIT pulses without success, the job ends with pass = 0 and `fail_sect` = the chosen sector.
- R5: An unlock pulse is a write of 60h to the sector base address with bit 6 = 1, bit 1 = 1 and bit 0 = 0. It is followed, at least UNPR_WAIT_US×CLK_MHZ cycles later, by a write of 40h and a read of the same address. A read-back of 00h means the sector is unlocked.
- R6: If a sector has not read back 00h after UNPR_LIMIT unlock pulses, the job ends with pass = 0 and `fail_sect` = that sector.
- R7: In whole-device mode, each sector 0..N_SECT-1 is first checked with a 40h write and a read at the lock address (bit 6 = 0). A read of 01h skips the sector. Any other value runs the lock loop of R3/R4 on that sector. If the lock budget runs out here, the job ends failed for that sector and no unlock pulse is issued.
- R8: After the check pass, unlock pulses start at sector 0 and move up by one sector after each 00h read-back, with the pulse count restarting at one. The job passes once the last sector verifies.
- R9: At the end of every job, `hv_en` falls before a write of F0h to address 0. After that write completes, `done` is high for exactly one cycle, and `busy` falls on the next cycle.
- R10: `start` has no effect while `busy` is high.
- R11: While `bus_req` is high and `bus_done` is low, the address, write data and direction of the request hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (sampled while idle) |
| unprot_all | input | 1 | 0: lock one sector, 1: unlock the whole device |
| sect_sel | input | 5 | Sector to lock in single-sector mode |
| busy | output | 1 | Job running |
| done | output | 1 | One-cycle end-of-job pulse |
| pass | output | 1 | Outcome of the last job |
| fail_sect | output | 5 | Sector that exhausted its pulse budget |
| hv_en | output | 1 | Request high voltage on the flash reset pin |
| bus_req | output | 1 | Bus cycle request, held until `bus_done` |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | ADDR_W | Bus cycle address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with `bus_done` |
| bus_done | input | 1 | Completion of the current bus cycle |

## Verification
The properties watch, on every cycle, the timing guarantees. These are the settle gap after the high-voltage flag rises, the minimum gap after a lock pulse or an unlock pulse before its verify write, the stability of a pending bus request, the dropped flag at the reset command, the single-cycle done pulse and quiet outputs while idle. Only the scenarios can show the order and count of the bus cycles. That covers the number of pulses before success or failure, the skip of sectors that are already locked, the abort on a failed check pass, the ascending sector walk, and the reported pass flag and failing sector index. The bench checks these against a queue of expected cycles, built from a device model with a chosen pulse count per sector.

// File: rtl/sgs_pkg.sv
package sgs_pkg;

    localparam int unsigned SGS_MAX_SECT = 32;
    localparam int unsigned SGS_IDX_W    = 5;

    typedef logic [SGS_MAX_SECT-1:0][31:0] sgs_base_tbl_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SETTLE, ST_PULSE, ST_WAIT, ST_VWR,
        ST_VRD, ST_HVOFF, ST_RSTCMD, ST_DONE
    } sgs_state_e;

    typedef enum logic [1:0] {
        PH_ONE, PH_PRE, PH_UNP
    } sgs_phase_e;

    localparam logic [7:0] CMD_PULSE  = 8'h60;
    localparam logic [7:0] CMD_VERIFY = 8'h40;
    localparam logic [7:0] CMD_RESET  = 8'hF0;
    localparam logic [7:0] RD_LOCKED  = 8'h01;
    localparam logic [7:0] RD_OPEN    = 8'h00;

    // bottom-boot layout: 16K, 8K, 8K, 32K, then 64K sectors
    function automatic sgs_base_tbl_t bottom_boot_tbl();
        sgs_base_tbl_t t;
        for (int i = 0; i < SGS_MAX_SECT; i++) begin
            case (i)
                0:       t[i] = 32'h0000_0000;
                1:       t[i] = 32'h0000_4000;
                2:       t[i] = 32'h0000_6000;
                3:       t[i] = 32'h0000_8000;
                default: t[i] = 32'(i - 3) << 16;
            endcase
        end
        return t;
    endfunction

endpackage

// File: rtl/sgs_timer.sv
module sgs_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sgs_addr_gen.sv
module sgs_addr_gen
    import sgs_pkg::*;
#(
    parameter int unsigned   ADDR_W    = 20,
    parameter sgs_base_tbl_t SECT_BASE = bottom_boot_tbl()
) (
    input  logic [SGS_IDX_W-1:0] sect,
    input  logic                 unlock,
    input  logic                 rst_cmd,
    output logic [ADDR_W-1:0]    addr
);
    localparam logic [ADDR_W-1:0] SEL_LOCK   = ADDR_W'(32'h0000_0002);
    localparam logic [ADDR_W-1:0] SEL_UNLOCK = ADDR_W'(32'h0000_0042);

    always_comb begin
        if (rst_cmd)
            addr = '0;
        else
            addr = SECT_BASE[sect][ADDR_W-1:0] | (unlock ? SEL_UNLOCK : SEL_LOCK);
    end
endmodule

// File: rtl/sgs_verdict.sv
module sgs_verdict #(
    parameter int unsigned CW         = 11,
    parameter int unsigned PROT_LIMIT = 25,
    parameter int unsigned UNPR_LIMIT = 1000
) (
    input  logic          unlock,
    input  logic [7:0]    rdata,
    input  logic [CW-1:0] pulses,
    output logic          ok,
    output logic          spent
);
    always_comb begin
        if (unlock) begin
            ok    = (rdata == sgs_pkg::RD_OPEN);
            spent = (pulses == CW'(UNPR_LIMIT));
        end else begin
            ok    = (rdata == sgs_pkg::RD_LOCKED);
            spent = (pulses == CW'(PROT_LIMIT));
        end
    end
endmodule

// File: rtl/sector_guard_seq.sv
module sector_guard_seq
    import sgs_pkg::*;
#(
    parameter int unsigned   CLK_MHZ      = 125,
    parameter int unsigned   SETTLE_US    = 1,
    parameter int unsigned   PROT_WAIT_US = 150,
    parameter int unsigned   UNPR_WAIT_US = 15000,
    parameter int unsigned   PROT_LIMIT   = 25,
    parameter int unsigned   UNPR_LIMIT   = 1000,
    parameter int unsigned   N_SECT       = 19,
    parameter int unsigned   ADDR_W       = 20,
    parameter sgs_base_tbl_t SECT_BASE    = bottom_boot_tbl()
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 unprot_all,
    input  logic [SGS_IDX_W-1:0] sect_sel,
    output logic                 busy,
    output logic                 done,
    output logic                 pass,
    output logic [SGS_IDX_W-1:0] fail_sect,
    output logic                 hv_en,
    output logic                 bus_req,
    output logic                 bus_we,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [7:0]           bus_wdata,
    input  logic [7:0]           bus_rdata,
    input  logic                 bus_done
);
    localparam int unsigned SETTLE_CYC = CLK_MHZ * SETTLE_US;
    localparam int unsigned PROT_CYC   = CLK_MHZ * PROT_WAIT_US;
    localparam int unsigned UNPR_CYC   = CLK_MHZ * UNPR_WAIT_US;
    localparam int unsigned MAX_W1     = (PROT_CYC > UNPR_CYC) ? PROT_CYC : UNPR_CYC;
    localparam int unsigned MAX_CYC    = (SETTLE_CYC > MAX_W1) ? SETTLE_CYC : MAX_W1;
    localparam int unsigned TW         = $clog2(MAX_CYC + 2);
    localparam int unsigned MAX_LIM    = (PROT_LIMIT > UNPR_LIMIT) ? PROT_LIMIT : UNPR_LIMIT;
    localparam int unsigned CW         = $clog2(MAX_LIM + 2);
    localparam logic [SGS_IDX_W-1:0] LAST = SGS_IDX_W'(N_SECT - 1);

    typedef struct packed {
        sgs_state_e           st;
        sgs_phase_e           ph;
        logic [SGS_IDX_W-1:0] sect;
        logic [CW-1:0]        cnt;
        logic                 hv;
        logic                 pass;
        logic [SGS_IDX_W-1:0] fsect;
    } ctl_t;

    ctl_t          c_d, c_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          v_ok, v_spent;

    sgs_timer #(.TW(TW)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sgs_addr_gen #(.ADDR_W(ADDR_W), .SECT_BASE(SECT_BASE)) agen_i (
        .sect    (c_q.sect),
        .unlock  (c_q.ph == PH_UNP),
        .rst_cmd (c_q.st == ST_RSTCMD),
        .addr    (bus_addr)
    );

    sgs_verdict #(.CW(CW), .PROT_LIMIT(PROT_LIMIT), .UNPR_LIMIT(UNPR_LIMIT)) vrd_i (
        .unlock (c_q.ph == PH_UNP),
        .rdata  (bus_rdata),
        .pulses (c_q.cnt),
        .ok     (v_ok),
        .spent  (v_spent)
    );

    always_comb begin
        c_d      = c_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.st    = ST_SETTLE;
                    c_d.hv    = 1'b1;
                    c_d.pass  = 1'b0;
                    c_d.fsect = '0;
                    if (unprot_all) begin
                        c_d.ph   = PH_PRE;
                        c_d.sect = '0;
                        c_d.cnt  = '0;
                    end else begin
                        c_d.ph   = PH_ONE;
                        c_d.sect = sect_sel;
                        c_d.cnt  = CW'(1);
                    end
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETTLE_CYC);
                end
            end
            ST_SETTLE: begin
                if (tmr_zero)
                    c_d.st = (c_q.cnt == '0) ? ST_VWR : ST_PULSE;
            end
            ST_PULSE: begin
                if (bus_done) begin
                    c_d.st   = ST_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = (c_q.ph == PH_UNP) ? TW'(UNPR_CYC) : TW'(PROT_CYC);
                end
            end
            ST_WAIT: begin
                if (tmr_zero) c_d.st = ST_VWR;
            end
            ST_VWR: begin
                if (bus_done) c_d.st = ST_VRD;
            end
            ST_VRD: begin
                if (bus_done) begin
                    if (v_ok) begin
                        case (c_q.ph)
                            PH_PRE: begin
                                if (c_q.sect == LAST) begin
                                    c_d.ph   = PH_UNP;
                                    c_d.sect = '0;
                                    c_d.cnt  = CW'(1);
                                    c_d.st   = ST_PULSE;
                                end else begin
                                    c_d.sect = c_q.sect + 1'b1;
                                    c_d.cnt  = '0;
                                    c_d.st   = ST_VWR;
                                end
                            end
                            PH_UNP: begin
                                if (c_q.sect == LAST) begin
                                    c_d.pass = 1'b1;
                                    c_d.hv   = 1'b0;
                                    c_d.st   = ST_HVOFF;
                                end else begin
                                    c_d.sect = c_q.sect + 1'b1;
                                    c_d.cnt  = CW'(1);
                                    c_d.st   = ST_PULSE;
                                end
                            end
                            default: begin
                                c_d.pass = 1'b1;
                                c_d.hv   = 1'b0;
                                c_d.st   = ST_HVOFF;
                            end
                        endcase
                    end else if (v_spent) begin
                        c_d.pass  = 1'b0;
                        c_d.fsect = c_q.sect;
                        c_d.hv    = 1'b0;
                        c_d.st    = ST_HVOFF;
                    end else begin
                        c_d.cnt = c_q.cnt + 1'b1;
                        c_d.st  = ST_PULSE;
                    end
                end
            end
            ST_HVOFF:  c_d.st = ST_RSTCMD;
            ST_RSTCMD: begin
                if (bus_done) c_d.st = ST_DONE;
            end
            ST_DONE:   c_d.st = ST_IDLE;
            default:   c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, ph: PH_ONE, default: '0};
        else        c_q <= c_d;
    end

    always_comb begin
        case (c_q.st)
            ST_PULSE:  bus_wdata = CMD_PULSE;
            ST_VWR:    bus_wdata = CMD_VERIFY;
            ST_RSTCMD: bus_wdata = CMD_RESET;
            default:   bus_wdata = 8'h00;
        endcase
    end

    assign bus_req   = (c_q.st == ST_PULSE) || (c_q.st == ST_VWR) ||
                       (c_q.st == ST_VRD)   || (c_q.st == ST_RSTCMD);
    assign bus_we    = (c_q.st != ST_VRD);
    assign busy      = (c_q.st != ST_IDLE);
    assign done      = (c_q.st == ST_DONE);
    assign pass      = c_q.pass;
    assign fail_sect = c_q.fsect;
    assign hv_en     = c_q.hv;
endmodule

// File: rtl/sgs_checker.sv
module sgs_checker #(
    parameter int unsigned SETTLE_CYC = 125,
    parameter int unsigned PROT_CYC   = 18750,
    parameter int unsigned UNPR_CYC   = 1875000,
    parameter int unsigned ADDR_W     = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              hv_en,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_done
);
    logic [31:0] hv_age, gap;
    logic        after_pulse, pulse_unl;

    always_ff @(posedge clk) begin
        if (!rst_n || !hv_en)           hv_age <= '0;
        else if (hv_age != 32'hFFFF_FFFF) hv_age <= hv_age + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap         <= '0;
            after_pulse <= 1'b0;
            pulse_unl   <= 1'b0;
        end else if (bus_req && bus_done) begin
            gap         <= '0;
            after_pulse <= bus_we && (bus_wdata == 8'h60);
            pulse_unl   <= bus_addr[6];
        end else if (gap != 32'hFFFF_FFFF) begin
            gap <= gap + 1'b1;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!hv_en && !bus_req && !done));

    a_r2_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && hv_en) |-> (hv_age >= SETTLE_CYC));

    a_r3_lock_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_wdata == 8'h40 && after_pulse && !pulse_unl)
        |-> (gap >= PROT_CYC));

    a_r5_unlock_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_wdata == 8'h40 && after_pulse && pulse_unl)
        |-> (gap >= UNPR_CYC));

    a_r9_reset_cmd_low_hv: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_wdata == 8'hF0) |-> !hv_en);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=>
        (bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)));
endmodule

bind sector_guard_seq sgs_checker #(
    .SETTLE_CYC (SETTLE_CYC),
    .PROT_CYC   (PROT_CYC),
    .UNPR_CYC   (UNPR_CYC),
    .ADDR_W     (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .hv_en     (hv_en),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_done  (bus_done)
);

// File: tb/sector_guard_seq_tb_top.sv
module sector_guard_seq_tb_top;
    localparam int CLK_MHZ = 8;
    localparam int SET_US  = 1;
    localparam int PW_US   = 4;
    localparam int UW_US   = 10;
    localparam int PL      = 25;
    localparam int UL      = 30;
    localparam int NS      = 19;
    localparam int AW      = 20;
    localparam int SET_CYC = CLK_MHZ * SET_US;
    localparam int PW_CYC  = CLK_MHZ * PW_US;
    localparam int UW_CYC  = CLK_MHZ * UW_US;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, unprot_all = 1'b0;
    logic [4:0] sect_sel = '0;
    logic busy, done, pass, hv_en, bus_req, bus_we;
    logic [4:0] fail_sect;
    logic [AW-1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata = '0;
    logic bus_done = 1'b0;

    sector_guard_seq #(
        .CLK_MHZ(CLK_MHZ), .SETTLE_US(SET_US), .PROT_WAIT_US(PW_US),
        .UNPR_WAIT_US(UW_US), .PROT_LIMIT(PL), .UNPR_LIMIT(UL),
        .N_SECT(NS), .ADDR_W(AW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .unprot_all(unprot_all),
        .sect_sel(sect_sel), .busy(busy), .done(done), .pass(pass),
        .fail_sect(fail_sect), .hv_en(hv_en), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_done(bus_done)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0, dones = 0;

    typedef struct { bit we; logic [AW-1:0] addr; logic [7:0] data; string tag; } exp_t;
    typedef struct { bit ok; int fs; string tag; } res_t;
    exp_t exp_q[$];
    res_t res_q[$];

    // device model
    int need_p[NS], need_u[NS], pc[NS], uc[NS];
    bit prot[NS];

    function automatic logic [AW-1:0] base_of(int i);
        case (i)
            0: return 20'h00000;
            1: return 20'h04000;
            2: return 20'h06000;
            3: return 20'h08000;
            default: return AW'((i - 3) << 16);
        endcase
    endfunction

    function automatic int sect_of(logic [AW-1:0] a);
        for (int i = 0; i < NS; i++)
            if (base_of(i) == (a & ~20'h00042)) return i;
        return -1;
    endfunction

    task automatic chk(bit cond, string tag, string what, int act, int expv);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic push(bit we, logic [AW-1:0] a, logic [7:0] d, string tag);
        exp_t e;
        e.we = we; e.addr = a; e.data = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic push_res(bit ok, int fs, string tag);
        res_t r;
        r.ok = ok; r.fs = fs; r.tag = tag;
        res_q.push_back(r);
    endtask

    // driver side: predicted lock loop for sector s
    task automatic plan_lock(int s, bit check_first, string tag, output bit ok);
        logic [AW-1:0] a;
        int n;
        a = base_of(s) | 20'h00002;
        ok = 1'b0;
        if (check_first) begin
            push(1, a, 8'h40, "R7");
            push(0, a, 8'h00, "R7");
            if (prot[s]) begin ok = 1'b1; return; end
        end
        n = prot[s] ? 1 : need_p[s];
        for (int k = 1; k <= PL; k++) begin
            push(1, a, 8'h60, tag);
            push(1, a, 8'h40, tag);
            push(0, a, 8'h00, tag);
            if (k >= n) begin ok = 1'b1; return; end
        end
    endtask

    task automatic plan_single(int s);
        bit ok;
        plan_lock(s, 1'b0, "R3", ok);
        push(1, '0, 8'hF0, "R9");
        push_res(ok, ok ? 0 : s, "R4");
    endtask

    task automatic plan_all();
        bit ok, lok;
        logic [AW-1:0] a;
        ok = 1'b1;
        for (int s = 0; s < NS && ok; s++) begin
            plan_lock(s, 1'b1, "R7", lok);
            if (!lok) begin ok = 1'b0; push_res(0, s, "R7"); end
        end
        if (ok) begin
            for (int s = 0; s < NS && ok; s++) begin
                a = base_of(s) | 20'h00042;
                for (int k = 1; k <= UL; k++) begin
                    push(1, a, 8'h60, (k == 1) ? "R8" : "R5");
                    push(1, a, 8'h40, "R5");
                    push(0, a, 8'h00, "R5");
                    if (k >= need_u[s]) break;
                    if (k == UL) begin ok = 1'b0; push_res(0, s, "R6"); end
                end
            end
            if (ok) push_res(1, 0, "R8");
        end
        push(1, '0, 8'hF0, "R9");
    endtask

    // monitor / bus responder
    int hv_rise = 0, last_done = 0;
    bit fresh_hv = 1'b0, hv_prev = 1'b0, last_pulse = 1'b0, last_unl = 1'b0;

    always @(negedge clk) begin
        if (hv_en && !hv_prev) begin hv_rise = cyc; fresh_hv = 1'b1; end
        hv_prev = hv_en;
    end

    initial begin
        exp_t e;
        int s, g, w;
        bit cwe;
        logic [AW-1:0] ca;
        logic [7:0] cd, rd;
        forever begin
            @(negedge clk);
            if (rst_n && bus_req) begin
                cwe = bus_we; ca = bus_addr; cd = bus_wdata;
                if (exp_q.size() == 0) begin
                    chk(0, "R10", "unexpected bus cycle addr", int'(ca), 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(cwe == e.we, e.tag, "bus direction", int'(cwe), int'(e.we));
                    chk(ca == e.addr, e.tag, "bus address", int'(ca), int'(e.addr));
                    if (e.we) chk(cd == e.data, e.tag, "write data", int'(cd), int'(e.data));
                end
                if (fresh_hv) begin
                    chk(cyc - hv_rise >= SET_CYC, "R2", "settle cycles", cyc - hv_rise, SET_CYC);
                    fresh_hv = 1'b0;
                end
                if (cwe && cd == 8'h40 && last_pulse) begin
                    g = cyc - last_done;
                    w = last_unl ? UW_CYC : PW_CYC;
                    chk(g >= w, last_unl ? "R5" : "R3", "wait after pulse", g, w);
                end
                if (cwe && cd == 8'hF0)
                    chk(hv_en == 1'b0, "R9", "hv_en at reset command", int'(hv_en), 0);
                s = sect_of(ca);
                rd = 8'h00;
                if (s >= 0) begin
                    if (cwe && cd == 8'h60) begin
                        if (ca[6]) begin uc[s]++; if (uc[s] >= need_u[s]) prot[s] = 1'b0; end
                        else       begin pc[s]++; if (pc[s] >= need_p[s]) prot[s] = 1'b1; end
                    end
                    if (!cwe) rd = prot[s] ? 8'h01 : 8'h00;
                end
                repeat (2) @(negedge clk);
                bus_done = 1'b1;
                bus_rdata = rd;
                last_done = cyc;
                last_pulse = cwe && (cd == 8'h60);
                last_unl = ca[6];
                @(negedge clk);
                bus_done = 1'b0;
                bus_rdata = 8'h00;
            end
        end
    end

    // result monitor
    initial begin
        res_t r;
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                dones++;
                if (res_q.size() == 0) begin
                    chk(0, "R9", "unexpected done", 1, 0);
                end else begin
                    r = res_q.pop_front();
                    chk(pass == r.ok, r.tag, "pass flag", int'(pass), int'(r.ok));
                    if (!r.ok) chk(int'(fail_sect) == r.fs, r.tag, "failing sector", int'(fail_sect), r.fs);
                end
                @(negedge clk);
                chk(done == 1'b0, "R9", "done width", int'(done), 0);
                chk(busy == 1'b0, "R9", "busy after done", int'(busy), 0);
            end
        end
    end

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 190000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
            finish_up();
        end
    end

    task automatic clear_model();
        for (int i = 0; i < NS; i++) begin
            need_p[i] = 1; need_u[i] = 1; pc[i] = 0; uc[i] = 0; prot[i] = 1'b0;
        end
    endtask

    task automatic go(bit all, int s);
        int d0;
        d0 = dones;
        @(negedge clk);
        start = 1'b1; unprot_all = all; sect_sel = 5'(s);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && hv_en == 1'b1, "R2", "busy and hv_en after start",
            int'({busy, hv_en}), 3);
    endtask

    task automatic finish_case(int d0, string tag);
        int t;
        t = 0;
        while (dones == d0 && t < 60000) begin @(negedge clk); t++; end
        chk(dones != d0, tag, "job completion", dones - d0, 1);
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, tag, "pending expected cycles", exp_q.size(), 0);
        chk(busy == 1'b0 && bus_req == 1'b0 && hv_en == 1'b0, "R1",
            "quiet after job", int'({busy, bus_req, hv_en}), 0);
    endtask

    initial begin
        int d0;
        clear_model();
        repeat (4) @(negedge clk);
        chk(busy == 0 && done == 0 && hv_en == 0 && bus_req == 0, "R1", "reset outputs",
            int'({busy, done, hv_en, bus_req}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 0 && hv_en == 0 && bus_req == 0, "R1", "idle outputs",
            int'({busy, hv_en, bus_req}), 0);

        // lock one sector, three pulses needed (R3, R4)
        clear_model(); need_p[5] = 3;
        plan_single(5);
        d0 = dones; go(0, 5); finish_case(d0, "R4");
        chk(prot[5] == 1'b1, "R4", "sector 5 locked", int'(prot[5]), 1);

        // lock sector 0, one pulse; start during busy ignored (R10)
        clear_model();
        plan_single(0);
        d0 = dones; go(0, 0);
        repeat (15) @(negedge clk);
        chk(busy == 1'b1, "R10", "busy during job", int'(busy), 1);
        start = 1'b1; unprot_all = 1'b1; sect_sel = 5'd9;
        @(negedge clk); start = 1'b0;
        finish_case(d0, "R10");

        // lock budget exhausted on last sector (R4)
        clear_model(); need_p[18] = 99;
        plan_single(18);
        d0 = dones; go(0, 18); finish_case(d0, "R4");
        chk(pc[18] == PL, "R4", "lock pulses issued", pc[18], PL);

        // whole-device unlock, mixed start state (R7, R8, R5)
        clear_model();
        for (int i = 0; i < NS; i++) begin
            prot[i] = (i % 2 == 0); need_p[i] = 2; need_u[i] = 1 + (i % 3);
        end
        plan_all();
        d0 = dones; go(1, 0); finish_case(d0, "R8");
        begin
            int nlock;
            nlock = 0;
            for (int i = 0; i < NS; i++) nlock += prot[i];
            chk(nlock == 0, "R8", "sectors still locked", nlock, 0);
        end

        // unlock budget exhausted at sector 7 (R6)
        clear_model();
        for (int i = 0; i < NS; i++) prot[i] = 1'b1;
        need_u[7] = 99;
        plan_all();
        d0 = dones; go(1, 0); finish_case(d0, "R6");
        chk(uc[7] == UL, "R6", "unlock pulses on sector 7", uc[7], UL);

        // check pass fails on sector 4, no unlock pulses (R7)
        clear_model();
        for (int i = 0; i < NS; i++) prot[i] = 1'b1;
        prot[4] = 1'b0; need_p[4] = 99;
        plan_all();
        d0 = dones; go(1, 0); finish_case(d0, "R7");
        begin
            int nu;
            nu = 0;
            for (int i = 0; i < NS; i++) nu += uc[i];
            chk(nu == 0, "R7", "unlock pulses after failed check pass", nu, 0);
        end

        finish_up();
    end
endmodule